// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Drive Modes

This block owns eight general-purpose pads and exposes them through a small word-addressed register bus. Each pin has a two-bit drive mode: push-pull output, input, open-drain or open-source. Each pin also has an output source switch. With the switch clear, the pin's bit of a software data-out register sets the effective output value. With the switch set, a per-pin three-bit selector picks one of eight peripheral signals instead. The mode then turns that effective value into a drive value and a drive enable for the pad.

Software can change data-out bits atomically through set, clear and toggle strobe registers. A second and a third window give byte-wide access to the lower and upper four mode fields. Pad inputs cross into the block clock through a two-flop synchronizer. The data-in register shows a pin's synchronized value only while that pin's digital input buffer is enabled. Reads are combinational on the current address. Writes take effect on the rising clock edge where `req_i` and `we_i` are high.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset every register reads 0. Every pin is in push-pull mode with data-out as its source, so `pad_oe_o` = 0xFF, `pad_out_o` = 0x00 and `pad_ie_o` = 0x00.
- R2: The mode register (offset 0x00) holds pin n in bits [2n+1:2n], with codes 0 push-pull, 1 input, 2 open-drain, 3 open-source. Offset 0x40 reads and writes pins 0–3 in bits [7:0], and offset 0x44 does the same for pins 4–7. All three offsets share one storage.
- R3: In push-pull mode the pad drive enable is 1 and the drive value is the effective output value.
- R4: When a pin's bit in the source-switch register (0x08) is 1, its effective output is `periph_i[sel]`, where sel is bits [2:0] of that pin's selector word at 0x20 + 4·n. When the bit is 0, the effective output is the data-out bit (0x0C).
- R5: In open-drain mode the drive value is 0, and the drive enable is the inverse of the effective output.
- R6: In open-source mode the drive value is 1, and the drive enable equals the effective output.
- R7: In input mode the drive enable is 0. In every mode `pad_ie_o[n]` follows bit n of the input-enable register (0x04).
- R8: Data-in (0x10) bit n equals `pad_in_i[n]` as sampled two rising edges earlier when input-enable bit n is 1. Otherwise it reads 0. Writes to 0x10 are ignored.
- R9: Writing to 0x14, 0x18 or 0x1C sets, clears or inverts the data-out bits that are 1 in the write data. Zero bits leave data-out unchanged, and these three offsets read as 0.
- R10: Register bits above each field's width read as 0, and writes to them are ignored. Unmapped offsets read as 0, and writes to them change nothing.
- R11: Only one access is taken per cycle. A strobe write and a later direct data-out write apply in bus order, so the last write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| periph_i | input | 8 | Peripheral signals, indexed by selector code |
| pad_in_i | input | 8 | Raw pad input levels |
| pad_out_o | output | 8 | Pad drive value |
| pad_oe_o | output | 8 | Pad drive enable |
| pad_ie_o | output | 8 | Pad digital input buffer enable |

## Verification
A corrupted mode field or source selector shows up on the pad outputs in the same cycle. It shows up as a pin that is driven when it should be released, driven to the wrong level, or following the wrong peripheral bit. Damage to the data-out or alias storage appears at the next read of any of its windows and on the pads of push-pull pins. A synchronizer with the wrong depth or a missing input gate is visible at data-in exactly two edges after a pad change. The bench model therefore compares all three pad vectors and the read data every cycle, so a fault is reported within one clock of becoming observable.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int REG_AW = 7;

  typedef enum logic [1:0] {
    PM_PUSH   = 2'd0,
    PM_IN     = 2'd1,
    PM_ODRAIN = 2'd2,
    PM_OSRC   = 2'd3
  } pin_mode_e;

  localparam logic [REG_AW-1:0] OFF_MODE    = 7'h00;
  localparam logic [REG_AW-1:0] OFF_IEN     = 7'h04;
  localparam logic [REG_AW-1:0] OFF_PSW     = 7'h08;
  localparam logic [REG_AW-1:0] OFF_DOUT    = 7'h0C;
  localparam logic [REG_AW-1:0] OFF_DIN     = 7'h10;
  localparam logic [REG_AW-1:0] OFF_SET     = 7'h14;
  localparam logic [REG_AW-1:0] OFF_CLR     = 7'h18;
  localparam logic [REG_AW-1:0] OFF_TGL     = 7'h1C;
  localparam logic [REG_AW-1:0] OFF_SEL0    = 7'h20;
  localparam logic [REG_AW-1:0] OFF_MODE_LO = 7'h40;
  localparam logic [REG_AW-1:0] OFF_MODE_HI = 7'h44;
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio8_pin.sv
module gpio8_pin
  import gpio8_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NSRC = 1 << SEL_W
) (
  input  pin_mode_e        mode_i,
  input  logic             psw_i,
  input  logic             dout_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSRC-1:0]  periph_i,
  input  logic             ien_i,
  output logic             pad_out_o,
  output logic             pad_oe_o,
  output logic             pad_ie_o
);
  logic eff;

  assign eff = psw_i ? periph_i[sel_i] : dout_i;

  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    unique case (mode_i)
      PM_PUSH:   begin pad_out_o = eff;  pad_oe_o = 1'b1; end
      PM_IN:     begin pad_out_o = 1'b0; pad_oe_o = 1'b0; end
      PM_ODRAIN: begin pad_out_o = 1'b0; pad_oe_o = ~eff; end
      PM_OSRC:   begin pad_out_o = 1'b1; pad_oe_o = eff;  end
      default:   begin pad_out_o = 1'b0; pad_oe_o = 1'b0; end
    endcase
  end

  assign pad_ie_o = ien_i;
endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int SEL_W = 3,
  parameter int DW    = 32,
  localparam int MW   = 2 * NPIN,
  localparam int HW   = MW / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NPIN-1:0]    din_i,
  output logic [MW-1:0]      mode_o,
  output logic [NPIN-1:0]    ien_o,
  output logic [NPIN-1:0]    psw_o,
  output logic [NPIN-1:0]    dout_o,
  output logic [NPIN*SEL_W-1:0] sel_o,
  output logic [DW-1:0]      rdata_o
);
  logic [MW-1:0]    mode_q;
  logic [NPIN-1:0]  ien_q, psw_q, dout_q;
  logic [SEL_W-1:0] sel_q [NPIN];
  logic             wr;
  logic [NPIN-1:0]  wbits;
  logic             unused_wdata;

  assign wr    = req_i & we_i;
  assign wbits = wdata_i[NPIN-1:0];
  assign unused_wdata = ^wdata_i[DW-1:MW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ien_q  <= '0;
      psw_q  <= '0;
      dout_q <= '0;
      for (int n = 0; n < NPIN; n++) sel_q[n] <= '0;
    end else if (wr) begin
      case (addr_i)
        OFF_MODE:    mode_q <= wdata_i[MW-1:0];
        OFF_MODE_LO: mode_q[HW-1:0] <= wdata_i[HW-1:0];
        OFF_MODE_HI: mode_q[MW-1:HW] <= wdata_i[HW-1:0];
        OFF_IEN:     ien_q  <= wbits;
        OFF_PSW:     psw_q  <= wbits;
        OFF_DOUT:    dout_q <= wbits;
        OFF_SET:     dout_q <= dout_q | wbits;
        OFF_CLR:     dout_q <= dout_q & ~wbits;
        OFF_TGL:     dout_q <= dout_q ^ wbits;
        default: ;
      endcase
      for (int n = 0; n < NPIN; n++)
        if (addr_i == REG_AW'(OFF_SEL0 + 4*n)) sel_q[n] <= wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_MODE:    rdata_o = DW'(mode_q);
      OFF_MODE_LO: rdata_o = DW'(mode_q[HW-1:0]);
      OFF_MODE_HI: rdata_o = DW'(mode_q[MW-1:HW]);
      OFF_IEN:     rdata_o = DW'(ien_q);
      OFF_PSW:     rdata_o = DW'(psw_q);
      OFF_DOUT:    rdata_o = DW'(dout_q);
      OFF_DIN:     rdata_o = DW'(din_i & ien_q);
      default: ;
    endcase
    for (int n = 0; n < NPIN; n++)
      if (addr_i == REG_AW'(OFF_SEL0 + 4*n)) rdata_o = DW'(sel_q[n]);
  end

  assign mode_o = mode_q;
  assign ien_o  = ien_q;
  assign psw_o  = psw_q;
  assign dout_o = dout_q;
  generate
    for (genvar n = 0; n < NPIN; n++) begin : g_sel_out
      assign sel_o[n*SEL_W +: SEL_W] = sel_q[n];
    end
  endgenerate

  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_SET) |=> ((dout_o & $past(wbits)) == $past(wbits)));
  assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_CLR) |=> ((dout_o & $past(wbits)) == '0));
  assert_tgl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_TGL) |=> (dout_o == ($past(dout_o) ^ $past(wbits))));
  assert_strobe_rd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_SET || addr_i == OFF_CLR || addr_i == OFF_TGL) |-> (rdata_o == '0));
  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(mode_o));
  assert_din_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_DIN) |-> ((rdata_o[NPIN-1:0] & ~ien_o) == '0));
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
  import gpio8_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int SEL_W = 3,
  parameter int DW    = 32,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NSRC-1:0]   periph_i,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_ie_o
);
  logic [2*NPIN-1:0]     mode;
  logic [NPIN-1:0]       ien, psw, dout, din_sync;
  logic [NPIN*SEL_W-1:0] sel;

  gpio8_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (din_sync)
  );

  gpio8_regs #(.NPIN(NPIN), .SEL_W(SEL_W), .DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .din_i  (din_sync),
    .mode_o (mode),
    .ien_o  (ien),
    .psw_o  (psw),
    .dout_o (dout),
    .sel_o  (sel),
    .rdata_o(rdata_o)
  );

  generate
    for (genvar n = 0; n < NPIN; n++) begin : g_pin
      gpio8_pin #(.SEL_W(SEL_W)) u_pin (
        .mode_i   (pin_mode_e'(mode[2*n +: 2])),
        .psw_i    (psw[n]),
        .dout_i   (dout[n]),
        .sel_i    (sel[n*SEL_W +: SEL_W]),
        .periph_i (periph_i),
        .ien_i    (ien[n]),
        .pad_out_o(pad_out_o[n]),
        .pad_oe_o (pad_oe_o[n]),
        .pad_ie_o (pad_ie_o[n])
      );

      assert_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode[2*n +: 2] == 2'd0 && !psw[n]) |-> (pad_oe_o[n] && pad_out_o[n] == dout[n]));
      assert_odrain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode[2*n +: 2] == 2'd2) |-> !(pad_oe_o[n] && pad_out_o[n]));
      assert_osrc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode[2*n +: 2] == 2'd3) |-> !(pad_oe_o[n] && !pad_out_o[n]));
      assert_input_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode[2*n +: 2] == 2'd1) |-> !pad_oe_o[n]);
    end
  endgenerate
endmodule

// File: tb/gpio8_ctrl_test.sv
module gpio8_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  periph = '0, pad_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_ie;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio8_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .periph_i(periph), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_ie_o(pad_ie)
  );

  // behavioural reference model
  int m_mode [8];
  int m_sel  [8];
  int m_ien, m_psw, m_dout, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mode[p]) begin m_mode[p] = 0; m_sel[p] = 0; end
      m_ien = 0; m_psw = 0; m_dout = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = int'(pad_in);
      if (req && we) begin
        int w;
        w = int'(wdata);
        case (int'(addr))
          'h00: for (int p = 0; p < 8; p++) m_mode[p] = (w >> (2*p)) & 3;
          'h40: for (int p = 0; p < 4; p++) m_mode[p] = (w >> (2*p)) & 3;
          'h44: for (int p = 4; p < 8; p++) m_mode[p] = (w >> (2*(p-4))) & 3;
          'h04: m_ien  = w & 'hFF;
          'h08: m_psw  = w & 'hFF;
          'h0C: m_dout = w & 'hFF;
          'h14: m_dout = m_dout | (w & 'hFF);
          'h18: m_dout = m_dout & ~w & 'hFF;
          'h1C: m_dout = (m_dout ^ w) & 'hFF;
          default:
            if (addr >= 7'h20 && addr <= 7'h3C && addr[1:0] == 2'b00)
              m_sel[(int'(addr) - 'h20) / 4] = w & 7;
        endcase
      end
    end
  end

  function automatic int model_read(int a);
    int r;
    r = 0;
    case (a)
      'h00: for (int p = 0; p < 8; p++) r |= m_mode[p] << (2*p);
      'h40: for (int p = 0; p < 4; p++) r |= m_mode[p] << (2*p);
      'h44: for (int p = 4; p < 8; p++) r |= m_mode[p] << (2*(p-4));
      'h04: r = m_ien;
      'h08: r = m_psw;
      'h0C: r = m_dout;
      'h10: r = m_s2 & m_ien;
      default:
        if (a >= 'h20 && a <= 'h3C && (a % 4) == 0) r = m_sel[(a - 'h20) / 4];
    endcase
    return r;
  endfunction

  function automatic string read_tag(int a);
    if (a == 'h00 || a == 'h40 || a == 'h44) return "R2";
    if (a == 'h08 || (a >= 'h20 && a <= 'h3C)) return "R4";
    if (a == 'h10) return "R8";
    if (a == 'h14 || a == 'h18 || a == 'h1C) return "R9";
    if (a == 'h04 || a == 'h0C) return "R11";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int a;
      a = int'(addr);
      chk(read_tag(a), rdata, 32'(model_read(a)));
      for (int p = 0; p < 8; p++) begin
        int eff, eo, ee;
        string tag;
        eff = ((m_psw >> p) & 1) ? int'(periph[m_sel[p]]) : ((m_dout >> p) & 1);
        case (m_mode[p])
          0: begin eo = eff; ee = 1;       tag = "R3"; end
          1: begin eo = 0;   ee = 0;       tag = "R7"; end
          2: begin eo = 0;   ee = 1 - eff; tag = "R5"; end
          default: begin eo = 1; ee = eff; tag = "R6"; end
        endcase
        if ((m_psw >> p) & 1) tag = "R4";
        chk(tag, {pad_out[p], pad_oe[p]}, {1'(eo), 1'(ee)});
        chk("R7", 32'(pad_ie[p]), 32'((m_ien >> p) & 1));
      end
    end
  end

  // bus tasks: entered and left at a falling edge
  task automatic wr(logic [6:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1: watchdog actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    #2;
    chk("R1 pad_oe", 32'(pad_oe), 32'hFF);
    chk("R1 pad_out", 32'(pad_out), 32'h00);
    chk("R1 pad_ie", 32'(pad_ie), 32'h00);
    @(negedge clk);
    for (int a = 0; a <= 'h44; a += 4) begin
      rd(7'(a), v);
      chk("R1 reg", v, 0);
    end

    // R3 push-pull from data-out
    wr(7'h0C, 32'hFFFF_FFA5);
    #2 chk("R3 drive", 32'(pad_out), 32'hA5);
    @(negedge clk);
    rd(7'h0C, v); chk("R10 dout width", v, 32'hA5);

    // R9 strobes
    wr(7'h14, 32'h0F); rd(7'h0C, v); chk("R9 set", v, 32'hAF);
    wr(7'h18, 32'hA0); rd(7'h0C, v); chk("R9 clear", v, 32'h0F);
    wr(7'h1C, 32'h3C); rd(7'h0C, v); chk("R9 toggle", v, 32'h33);
    wr(7'h14, 32'h00); rd(7'h0C, v); chk("R9 zero set", v, 32'h33);
    rd(7'h1C, v); chk("R9 read zero", v, 0);

    // R11 last write wins
    wr(7'h14, 32'hFF); wr(7'h0C, 32'h01); rd(7'h0C, v); chk("R11 order", v, 32'h01);
    wr(7'h0C, 32'h0F);

    // R2 mode and aliases
    wr(7'h00, 32'h0000_1BE4);
    rd(7'h40, v); chk("R2 lo alias", v, 32'hE4);
    rd(7'h44, v); chk("R2 hi alias", v, 32'h1B);
    wr(7'h44, 32'hFFFF_FF00);
    rd(7'h00, v); chk("R2 hi write", v, 32'h00E4);
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h00, v); chk("R10 mode width", v, 32'hFFFF);

    // R6 open-source, R5 open-drain, R7 input
    #2 chk("R6 oe", 32'(pad_oe), 32'h0F);
    chk("R6 out", 32'(pad_out), 32'hFF);
    @(negedge clk);
    wr(7'h00, 32'hAAAA);
    #2 chk("R5 oe", 32'(pad_oe), 32'hF0);
    chk("R5 out", 32'(pad_out), 32'h00);
    @(negedge clk);
    wr(7'h04, 32'h5A);
    wr(7'h00, 32'h5555);
    #2 chk("R7 oe", 32'(pad_oe), 32'h00);
    chk("R7 ie", 32'(pad_ie), 32'h5A);
    @(negedge clk);

    // R4 peripheral routing
    wr(7'h00, 32'h0);
    for (int n = 0; n < 8; n++) wr(7'(32'h20 + 4*n), 32'hFFFF_FFF8 | 32'(7 - n));
    rd(7'h24, v); chk("R10 sel width", v, 32'h6);
    wr(7'h08, 32'hFF);
    periph = 8'h0E;
    #2 chk("R4 reversed", 32'(pad_out), 32'h70);
    @(negedge clk);

    // R8 synchronizer latency and gating
    wr(7'h04, 32'hFF);
    pad_in = 8'hC3;
    rd(7'h10, v); chk("R8 edge0", v, 32'h00);
    rd(7'h10, v); chk("R8 edge1", v, 32'h00);
    rd(7'h10, v); chk("R8 edge2", v, 32'hC3);
    wr(7'h04, 32'h0F);
    rd(7'h10, v); chk("R8 gated", v, 32'h03);
    wr(7'h10, 32'hFF);
    rd(7'h10, v); chk("R8 read-only", v, 32'h03);

    // R10 unmapped
    wr(7'h48, 32'hFFFF_FFFF);
    rd(7'h48, v); chk("R10 unmapped", v, 0);
    rd(7'h7C, v); chk("R10 unmapped hi", v, 0);

    // mixed traffic, checked each cycle against the model
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [6:0] a;
      k = $urandom_range(0, 21);
      a = (k < 18) ? 7'(4*k) : (k == 18) ? 7'h40 : (k == 19) ? 7'h44 : 7'(4*k + 8);
      periph = 8'($urandom);
      pad_in = 8'($urandom);
      if ($urandom_range(0, 2) != 0) wr(a, $urandom);
      else rd(a, v);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule